// File: doc/BRIEF.md
# Stack-Walk Prefetcher

This block keeps one last-in first-out stack of pending node addresses for each of several threads that walk a tree depth-first. A client pushes node addresses onto a thread's stack and pops them to visit nodes. Every successful pop sends the popped address out as a demand read one clock later.

Each thread has a small walk state machine that watches its own push and pop sequence. A pop that directly follows a push is a descent, and it issues nothing. A second or later pop in a row is a climb back up the tree. On a climb, the block issues prefetch requests for entries that are still waiting on that same stack: first the entry the next pop will return, then the entries below it. A per-thread marker stops any entry from being requested twice within one climb.

Requests go into a small queue with a valid/ready output port. When that queue is full, further requests are discarded, so demand reads are never held back.

The walk machine has three states:
- ST_IDLE: the stack is empty.
- ST_AFTER_PUSH: the last operation on the thread was a push.
- ST_POP_STREAK: at least one pop has followed the last push.

Its transitions are:
- push: from any state to ST_AFTER_PUSH.
- descend: ST_AFTER_PUSH to ST_POP_STREAK on a pop.
- climb: ST_POP_STREAK stays in ST_POP_STREAK on a pop. Each climb issues prefetches.
- drain: any pop that leaves the stack empty goes to ST_IDLE.

Top module: `stackwalk_prefetch`

## Requirements
- R1: After reset all stacks are empty and demand_valid, pf_valid, overflow, underflow and conflict_err are 0.
- R2: A pop of a non-empty stack returns the address most recently pushed to that thread and not yet popped. demand_valid is 1, with demand_addr and demand_tid, in the cycle after the pop is sampled. In every other cycle demand_valid is 0.
- R3: Threads are independent. A push to one thread and a pop from another in the same cycle both take effect. Another thread's operations do not end a thread's pop streak.
- R4: The first pop after a push of the same thread issues no prefetch request.
- R5: Each later pop with no push to that thread in between issues requests. Let c be the occupancy after the pop. The requests cover stack slots c-1 down to c-INTENSITY, stopping at slot 0, where slot 0 is the oldest entry. They are queued in that order: the entry the next pop will return first.
- R6: Within one streak, no slot is requested twice; a slot already requested is skipped. A push, and the descending pop after it, start a fresh streak in which any slot may be requested again.
- R7: Queued requests leave in order on pf_addr and pf_tid while pf_valid is 1. They hold steady while pf_ready is 0. A request that finds the queue full (full as measured before this cycle's dequeue) is discarded, and demand reads continue unaffected.
- R8: A push to a full stack sets the sticky overflow flag and leaves that stack unchanged.
- R9: A pop of an empty stack sets the sticky underflow flag, produces no demand read and leaves the stack unchanged.
- R10: A push and a pop to the same thread in one cycle set the sticky conflict_err flag, and neither operation takes effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| push_valid | input | 1 | Push request this cycle |
| push_tid | input | TID_W | Thread receiving the push |
| push_addr | input | ADDR_W | Node address pushed |
| pop_valid | input | 1 | Pop request this cycle |
| pop_tid | input | TID_W | Thread being popped |
| demand_valid | output | 1 | Demand read issued |
| demand_addr | output | ADDR_W | Address of the popped node |
| demand_tid | output | TID_W | Thread of the demand read |
| pf_valid | output | 1 | Prefetch request available |
| pf_ready | input | 1 | Consumer accepts the prefetch request |
| pf_addr | output | ADDR_W | Prefetch address |
| pf_tid | output | TID_W | Thread that produced the prefetch |
| overflow | output | 1 | Sticky: push to full stack seen |
| underflow | output | 1 | Sticky: pop of empty stack seen |
| conflict_err | output | 1 | Sticky: same-thread push and pop in one cycle |

## Verification
The bench targets several corner cases, each with the failure it would expose:
- The descending pop right after a push: a design that counts streaks wrongly prefetches there.
- Overlapping climbs: without a working marker, the same entry is requested twice. A marker that a push does not clear loses requests in the next streak.
- A streak on one thread interleaved with pops on another: a shared state machine would break the streak.
- A stalled consumer while the queue fills: a design that stalls or overwrites shows up as a mismatch in request order or in demand timing.
- Full-stack, empty-stack and same-thread collisions: the bench reads each stack back afterwards, so any corruption appears in the demand addresses.

// File: rtl/swp_pkg.sv
package swp_pkg;

    // Per-thread walk state, driven by the push/pop sequence of that thread
    typedef enum logic [1:0] {
        ST_IDLE       = 2'd0,
        ST_AFTER_PUSH = 2'd1,
        ST_POP_STREAK = 2'd2
    } walk_state_e;

endpackage

// File: rtl/swp_walk_fsm.sv
module swp_walk_fsm
    import swp_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic do_push,    // accepted push to this thread
    input  logic do_pop,     // accepted pop from this thread
    input  logic last_entry, // the pop removes the final entry
    output logic upward      // this pop is a climb: generate prefetches
);

    walk_state_e state_q;
    walk_state_e state_d;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: begin
                if (do_push) begin
                    state_d = ST_AFTER_PUSH;
                end
            end
            ST_AFTER_PUSH: begin
                if (do_pop) begin
                    state_d = last_entry ? ST_IDLE : ST_POP_STREAK;
                end
            end
            ST_POP_STREAK: begin
                if (do_push) begin
                    state_d = ST_AFTER_PUSH;
                end else if (do_pop && last_entry) begin
                    state_d = ST_IDLE;
                end
            end
            default: begin
                state_d = ST_IDLE;
            end
        endcase
    end

    always_comb begin
        upward = do_pop && (state_q == ST_POP_STREAK);
    end

endmodule

// File: rtl/swp_pick_range.sv
module swp_pick_range #(
    parameter int DEPTH     = 8,
    parameter int INTENSITY = 2,
    localparam int CNT_W    = $clog2(DEPTH + 1),
    localparam int K_W      = $clog2(INTENSITY + 1)
) (
    input  logic [CNT_W-1:0] new_cnt,  // occupancy after the pop
    input  logic [CNT_W-1:0] mark,     // lowest slot already requested this streak
    output logic [CNT_W-1:0] top_lim,  // one above the first slot to request
    output logic [CNT_W-1:0] low,      // lowest slot in the window
    output logic [K_W-1:0]   num       // number of slots to request
);

    localparam logic [CNT_W-1:0] INT_C = CNT_W'(INTENSITY);

    always_comb begin
        low     = (new_cnt >= INT_C) ? (new_cnt - INT_C) : '0;
        top_lim = (mark < new_cnt) ? mark : new_cnt;
        num     = (top_lim > low) ? K_W'(top_lim - low) : '0;
    end

endmodule

// File: rtl/swp_req_fifo.sv
module swp_req_fifo #(
    parameter int ADDR_W    = 32,
    parameter int TID_W     = 2,
    parameter int FD        = 4,   // power of two, at least 2
    parameter int NW        = 2,   // writes per cycle
    localparam int PTR_W    = $clog2(FD),
    localparam int FCNT_W   = $clog2(FD + 1),
    localparam int K_W      = $clog2(NW + 1),
    localparam int SUM_W    = ((FCNT_W > K_W) ? FCNT_W : K_W) + 1
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic [K_W-1:0]             wr_num,
    input  logic [NW-1:0][ADDR_W-1:0]  wr_addr,
    input  logic [NW-1:0][TID_W-1:0]   wr_tid,
    input  logic                       rd_ready,
    output logic                       rd_valid,
    output logic [ADDR_W-1:0]          rd_addr,
    output logic [TID_W-1:0]           rd_tid
);

    logic [ADDR_W-1:0] mem_addr_q [FD];
    logic [TID_W-1:0]  mem_tid_q  [FD];
    logic [PTR_W-1:0]  wptr_q;
    logic [PTR_W-1:0]  rptr_q;
    logic [FCNT_W-1:0] count_q;
    logic [SUM_W-1:0]  free_slots;
    logic [SUM_W-1:0]  accepted;
    logic              rd_fire;

    always_comb begin
        rd_fire    = (count_q != '0) && rd_ready;
        free_slots = SUM_W'(FD) - SUM_W'(count_q);
        accepted   = (SUM_W'(wr_num) > free_slots) ? free_slots : SUM_W'(wr_num);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            wptr_q  <= '0;
            rptr_q  <= '0;
            count_q <= '0;
            for (int i = 0; i < FD; i++) begin
                mem_addr_q[i] <= '0;
                mem_tid_q[i]  <= '0;
            end
        end else begin
            for (int j = 0; j < NW; j++) begin
                if (SUM_W'(j) < accepted) begin
                    mem_addr_q[wptr_q + PTR_W'(j)] <= wr_addr[j];
                    mem_tid_q[wptr_q + PTR_W'(j)]  <= wr_tid[j];
                end
            end
            wptr_q  <= wptr_q + PTR_W'(accepted);
            rptr_q  <= rptr_q + PTR_W'(rd_fire);
            count_q <= FCNT_W'(SUM_W'(count_q) + accepted - SUM_W'(rd_fire));
        end
    end

    always_comb begin
        rd_valid = (count_q != '0);
        rd_addr  = mem_addr_q[rptr_q];
        rd_tid   = mem_tid_q[rptr_q];
    end

endmodule

// File: rtl/stackwalk_prefetch.sv
module stackwalk_prefetch #(
    parameter int ADDR_W        = 32,
    parameter int THREADS       = 4,
    parameter int DEPTH         = 8,
    parameter int INTENSITY     = 2,
    parameter int PF_FIFO_DEPTH = 4,
    localparam int TID_W        = $clog2(THREADS)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              push_valid,
    input  logic [TID_W-1:0]  push_tid,
    input  logic [ADDR_W-1:0] push_addr,
    input  logic              pop_valid,
    input  logic [TID_W-1:0]  pop_tid,
    output logic              demand_valid,
    output logic [ADDR_W-1:0] demand_addr,
    output logic [TID_W-1:0]  demand_tid,
    output logic              pf_valid,
    input  logic              pf_ready,
    output logic [ADDR_W-1:0] pf_addr,
    output logic [TID_W-1:0]  pf_tid,
    output logic              overflow,
    output logic              underflow,
    output logic              conflict_err
);

    localparam int CNT_W = $clog2(DEPTH + 1);
    localparam int IDX_W = $clog2(DEPTH);
    localparam int K_W   = $clog2(INTENSITY + 1);
    localparam logic [CNT_W-1:0] DEPTH_C = CNT_W'(DEPTH);

    // Stack storage, occupancy and streak marker per thread
    logic [ADDR_W-1:0] stk_q  [THREADS][DEPTH];
    logic [CNT_W-1:0]  cnt_q  [THREADS];
    logic [CNT_W-1:0]  mark_q [THREADS];

    logic              same_thread;
    logic              push_full;
    logic              pop_empty;
    logic              push_ok;
    logic              pop_ok;
    logic [CNT_W-1:0]  new_cnt;
    logic [IDX_W-1:0]  top_idx;

    logic [THREADS-1:0] fsm_push;
    logic [THREADS-1:0] fsm_pop;
    logic [THREADS-1:0] fsm_last;
    logic [THREADS-1:0] fsm_up;
    logic               upward;

    logic [CNT_W-1:0]  top_lim;
    logic [CNT_W-1:0]  win_low;
    logic [K_W-1:0]    win_num;
    logic [K_W-1:0]    fire_num;
    logic [INTENSITY-1:0][ADDR_W-1:0] pf_wr_addr;
    logic [INTENSITY-1:0][TID_W-1:0]  pf_wr_tid;

    logic              demand_valid_q;
    logic [ADDR_W-1:0] demand_addr_q;
    logic [TID_W-1:0]  demand_tid_q;
    logic              overflow_q;
    logic              underflow_q;
    logic              conflict_q;

    // Request qualification
    always_comb begin
        same_thread = push_valid && pop_valid && (push_tid == pop_tid);
        push_full   = (cnt_q[push_tid] == DEPTH_C);
        pop_empty   = (cnt_q[pop_tid] == '0);
        push_ok     = push_valid && !same_thread && !push_full;
        pop_ok      = pop_valid && !same_thread && !pop_empty;
        new_cnt     = cnt_q[pop_tid] - CNT_W'(1);
        top_idx     = IDX_W'(new_cnt);
    end

    // One walk machine per thread
    for (genvar t = 0; t < THREADS; t++) begin : g_walk
        assign fsm_push[t] = push_ok && (push_tid == TID_W'(t));
        assign fsm_pop[t]  = pop_ok && (pop_tid == TID_W'(t));
        assign fsm_last[t] = (cnt_q[t] == CNT_W'(1));

        swp_walk_fsm walk_i (
            .clk        (clk),
            .rst_n      (rst_n),
            .do_push    (fsm_push[t]),
            .do_pop     (fsm_pop[t]),
            .last_entry (fsm_last[t]),
            .upward     (fsm_up[t])
        );
    end

    assign upward = fsm_up[pop_tid];

    swp_pick_range #(
        .DEPTH     (DEPTH),
        .INTENSITY (INTENSITY)
    ) range_i (
        .new_cnt (new_cnt),
        .mark    (mark_q[pop_tid]),
        .top_lim (top_lim),
        .low     (win_low),
        .num     (win_num)
    );

    // Gather prefetch addresses from the popped thread's stack
    always_comb begin
        logic [CNT_W-1:0] slot;
        fire_num = upward ? win_num : '0;
        for (int j = 0; j < INTENSITY; j++) begin
            slot          = top_lim - CNT_W'(j + 1);
            pf_wr_addr[j] = (K_W'(j) < win_num) ? stk_q[pop_tid][IDX_W'(slot)] : '0;
            pf_wr_tid[j]  = pop_tid;
        end
    end

    swp_req_fifo #(
        .ADDR_W (ADDR_W),
        .TID_W  (TID_W),
        .FD     (PF_FIFO_DEPTH),
        .NW     (INTENSITY)
    ) fifo_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_num   (fire_num),
        .wr_addr  (pf_wr_addr),
        .wr_tid   (pf_wr_tid),
        .rd_ready (pf_ready),
        .rd_valid (pf_valid),
        .rd_addr  (pf_addr),
        .rd_tid   (pf_tid)
    );

    // Stack, marker, demand and flag registers
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int t = 0; t < THREADS; t++) begin
                cnt_q[t]  <= '0;
                mark_q[t] <= DEPTH_C;
                for (int d = 0; d < DEPTH; d++) begin
                    stk_q[t][d] <= '0;
                end
            end
            demand_valid_q <= 1'b0;
            demand_addr_q  <= '0;
            demand_tid_q   <= '0;
            overflow_q     <= 1'b0;
            underflow_q    <= 1'b0;
            conflict_q     <= 1'b0;
        end else begin
            demand_valid_q <= pop_ok;
            if (pop_ok) begin
                demand_addr_q   <= stk_q[pop_tid][top_idx];
                demand_tid_q    <= pop_tid;
                cnt_q[pop_tid]  <= new_cnt;
                if (!upward) begin
                    mark_q[pop_tid] <= DEPTH_C;
                end else if (win_num != '0) begin
                    mark_q[pop_tid] <= win_low;
                end
            end
            if (push_ok) begin
                stk_q[push_tid][IDX_W'(cnt_q[push_tid])] <= push_addr;
                cnt_q[push_tid]  <= cnt_q[push_tid] + CNT_W'(1);
                mark_q[push_tid] <= DEPTH_C;
            end
            if (push_valid && !same_thread && push_full) begin
                overflow_q <= 1'b1;
            end
            if (pop_valid && !same_thread && pop_empty) begin
                underflow_q <= 1'b1;
            end
            if (same_thread) begin
                conflict_q <= 1'b1;
            end
        end
    end

    assign demand_valid = demand_valid_q;
    assign demand_addr  = demand_addr_q;
    assign demand_tid   = demand_tid_q;
    assign overflow     = overflow_q;
    assign underflow    = underflow_q;
    assign conflict_err = conflict_q;

endmodule

// File: rtl/swp_chk.sv
module swp_chk #(
    parameter int ADDR_W = 32,
    parameter int TID_W  = 2
) (
    input logic              clk,
    input logic              rst_n,
    input logic              push_valid,
    input logic [TID_W-1:0]  push_tid,
    input logic              pop_valid,
    input logic [TID_W-1:0]  pop_tid,
    input logic              demand_valid,
    input logic              pf_valid,
    input logic              pf_ready,
    input logic [ADDR_W-1:0] pf_addr,
    input logic [TID_W-1:0]  pf_tid,
    input logic              overflow,
    input logic              underflow,
    input logic              conflict_err
);

    // R2
    demand_from_pop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        demand_valid |-> $past(pop_valid));

    // R2
    no_pop_no_demand_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !pop_valid |=> !demand_valid);

    // R7
    pf_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (pf_valid && !pf_ready) |=> (pf_valid && $stable(pf_addr) && $stable(pf_tid)));

    // R8
    overflow_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        overflow |=> overflow);

    // R9
    underflow_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        underflow |=> underflow);

    // R10
    conflict_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (push_valid && pop_valid && (push_tid == pop_tid)) |=> conflict_err);

    // R10
    conflict_no_demand_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (push_valid && pop_valid && (push_tid == pop_tid)) |=> !demand_valid);

endmodule

bind stackwalk_prefetch swp_chk #(
    .ADDR_W (ADDR_W),
    .TID_W  (TID_W)
) chk_i (
    .clk          (clk),
    .rst_n        (rst_n),
    .push_valid   (push_valid),
    .push_tid     (push_tid),
    .pop_valid    (pop_valid),
    .pop_tid      (pop_tid),
    .demand_valid (demand_valid),
    .pf_valid     (pf_valid),
    .pf_ready     (pf_ready),
    .pf_addr      (pf_addr),
    .pf_tid       (pf_tid),
    .overflow     (overflow),
    .underflow    (underflow),
    .conflict_err (conflict_err)
);

// File: tb/stackwalk_prefetch_tb_top.sv
`timescale 1ns/1ps
module stackwalk_prefetch_tb_top;

    localparam int NT  = 4;
    localparam int DP  = 8;
    localparam int NI  = 2;
    localparam int FD  = 4;

    logic        clk;
    logic        rst_n;
    logic        push_valid;
    logic [1:0]  push_tid;
    logic [31:0] push_addr;
    logic        pop_valid;
    logic [1:0]  pop_tid;
    logic        demand_valid;
    logic [31:0] demand_addr;
    logic [1:0]  demand_tid;
    logic        pf_valid;
    logic        pf_ready;
    logic [31:0] pf_addr;
    logic [1:0]  pf_tid;
    logic        overflow;
    logic        underflow;
    logic        conflict_err;

    stackwalk_prefetch #(
        .ADDR_W (32), .THREADS (NT), .DEPTH (DP),
        .INTENSITY (NI), .PF_FIFO_DEPTH (FD)
    ) dut_i (
        .clk (clk), .rst_n (rst_n),
        .push_valid (push_valid), .push_tid (push_tid), .push_addr (push_addr),
        .pop_valid (pop_valid), .pop_tid (pop_tid),
        .demand_valid (demand_valid), .demand_addr (demand_addr), .demand_tid (demand_tid),
        .pf_valid (pf_valid), .pf_ready (pf_ready), .pf_addr (pf_addr), .pf_tid (pf_tid),
        .overflow (overflow), .underflow (underflow), .conflict_err (conflict_err)
    );

    initial clk = 1'b0;
    always #10 clk = ~clk;

    int    n_checks = 0;
    int    n_errors = 0;
    bit    done = 0;
    string phase = "R1";

    // Behavioural reference model
    logic [31:0] m_stk [NT][DP];
    int          m_sz   [NT];
    int          m_mode [NT];   // 0 empty, 1 last op push, 2 popping
    int          m_mark [NT];
    logic [31:0] m_pfa [$];
    int          m_pft [$];
    bit          e_dv, e_ovf, e_unf, e_conf;
    logic [31:0] e_da;
    int          e_dt;

    task automatic chk(input string what, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_errors++;
            $display("FAIL %s %s: actual=%h expected=%h", phase, what, act, exp);
        end
    endtask

    task automatic model_edge();
        int free_q;
        int t;
        int c;
        int lowest;
        free_q = FD - m_pfa.size();
        if (pf_ready && m_pfa.size() > 0) begin
            void'(m_pfa.pop_front());
            void'(m_pft.pop_front());
        end
        e_dv = 0;
        if (push_valid && pop_valid && push_tid == pop_tid) begin
            e_conf = 1;
        end else begin
            if (pop_valid) begin
                t = int'(pop_tid);
                if (m_sz[t] == 0) begin
                    e_unf = 1;
                end else begin
                    m_sz[t]--;
                    c    = m_sz[t];
                    e_da = m_stk[t][c];
                    e_dv = 1;
                    e_dt = t;
                    if (m_mode[t] == 2) begin
                        lowest = -1;
                        for (int s = c - 1; s >= 0 && s >= c - NI; s--) begin
                            if (s < m_mark[t]) begin
                                if (free_q > 0) begin
                                    m_pfa.push_back(m_stk[t][s]);
                                    m_pft.push_back(t);
                                    free_q--;
                                end
                                lowest = s;
                            end
                        end
                        if (lowest >= 0) m_mark[t] = lowest;
                    end else begin
                        m_mode[t] = 2;
                        m_mark[t] = DP;
                    end
                    if (c == 0) m_mode[t] = 0;
                end
            end
            if (push_valid) begin
                t = int'(push_tid);
                if (m_sz[t] == DP) begin
                    e_ovf = 1;
                end else begin
                    m_stk[t][m_sz[t]] = push_addr;
                    m_sz[t]++;
                    m_mode[t] = 1;
                    m_mark[t] = DP;
                end
            end
        end
    endtask

    task automatic compare();
        chk("demand_valid", {31'd0, demand_valid}, {31'd0, e_dv});
        if (e_dv) begin
            chk("demand_addr", demand_addr, e_da);
            chk("demand_tid", {30'd0, demand_tid}, e_dt);
        end
        chk("pf_valid", {31'd0, pf_valid}, (m_pfa.size() != 0) ? 32'd1 : 32'd0);
        if (m_pfa.size() != 0) begin
            chk("pf_addr", pf_addr, m_pfa[0]);
            chk("pf_tid", {30'd0, pf_tid}, m_pft[0]);
        end
        chk("overflow", {31'd0, overflow}, {31'd0, e_ovf});
        chk("underflow", {31'd0, underflow}, {31'd0, e_unf});
        chk("conflict_err", {31'd0, conflict_err}, {31'd0, e_conf});
    endtask

    task automatic step(input bit pv, input int pt, input logic [31:0] pa,
                        input bit ov, input int ot, input bit rdy);
        push_valid = pv;
        push_tid   = pt[1:0];
        push_addr  = pa;
        pop_valid  = ov;
        pop_tid    = ot[1:0];
        pf_ready   = rdy;
        @(posedge clk);
        model_edge();
        @(negedge clk);
        compare();
    endtask

    task automatic do_push(input int t, input logic [31:0] a);
        step(1, t, a, 0, 0, 1);
    endtask

    task automatic do_pop(input int t, input bit rdy);
        step(0, 0, 32'd0, 1, t, rdy);
    endtask

    task automatic idle(input int n, input bit rdy);
        for (int i = 0; i < n; i++) step(0, 0, 32'd0, 0, 0, rdy);
    endtask

    initial begin
        for (int t = 0; t < NT; t++) begin
            m_sz[t] = 0; m_mode[t] = 0; m_mark[t] = DP;
            for (int d = 0; d < DP; d++) m_stk[t][d] = '0;
        end
        e_dv = 0; e_da = '0; e_dt = 0; e_ovf = 0; e_unf = 0; e_conf = 0;
        rst_n = 1'b0;
        push_valid = 0; push_tid = '0; push_addr = '0;
        pop_valid = 0; pop_tid = '0; pf_ready = 1;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;

        // R1: everything idle and empty after reset
        phase = "R1";
        compare();
        idle(2, 1);
        do_pop(1, 1);   // empty stack after reset: underflow, no demand

        // R2: LIFO order and one-cycle demand latency
        phase = "R2";
        for (int i = 0; i < 6; i++) do_push(0, 32'h1000 + 32'(i) * 32'h40);
        // R4: descending pop, no prefetch
        phase = "R4";
        do_pop(0, 1);
        // R5: climbing pops prefetch from new top downward
        phase = "R5";
        do_pop(0, 1);
        // R6: later climbs skip already requested slots
        phase = "R6";
        do_pop(0, 1);
        do_pop(0, 1);
        do_pop(0, 1);
        do_pop(0, 1);
        idle(3, 1);
        // R6: a push restarts the streak so slots may be requested again
        for (int i = 0; i < 4; i++) do_push(0, 32'h2000 + 32'(i));
        do_pop(0, 1);
        do_pop(0, 1);
        do_push(0, 32'h2100);
        do_pop(0, 1);
        do_pop(0, 1);
        idle(3, 1);

        // R3: independent threads, same-cycle push and pop to different threads
        phase = "R3";
        for (int i = 0; i < 4; i++) do_push(1, 32'h3000 + 32'(i));
        for (int i = 0; i < 3; i++) do_push(2, 32'h4000 + 32'(i));
        step(1, 2, 32'h4003, 1, 1, 1);
        do_pop(1, 1);
        do_pop(2, 1);
        do_pop(1, 1);
        idle(3, 1);

        // R7: consumer stalled, queue fills, excess dropped, demand continues
        phase = "R7";
        for (int i = 0; i < 8; i++) do_push(3, 32'h5000 + 32'(i) * 32'h10);
        for (int i = 0; i < 5; i++) do_pop(3, 0);
        idle(2, 0);
        idle(5, 1);
        for (int i = 0; i < 3; i++) do_pop(3, 1);
        idle(3, 1);

        // R8: overflow leaves the stack intact
        phase = "R8";
        for (int i = 0; i < 10; i++) do_push(0, 32'h6000 + 32'(i));
        for (int i = 0; i < 8; i++) do_pop(0, 1);
        idle(4, 1);

        // R9: underflow on an empty stack, no demand
        phase = "R9";
        for (int i = 0; i < 5; i++) do_pop(2, 1);
        idle(3, 1);

        // R10: same-thread push and pop in one cycle do nothing
        phase = "R10";
        do_push(1, 32'h7000);
        step(1, 1, 32'h7001, 1, 1, 1);
        do_pop(1, 1);
        do_pop(1, 1);
        do_pop(1, 1);
        idle(4, 1);

        done = 1;
        $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
        $finish;
    end

    initial begin
        #(20ns * 20000);
        if (!done) begin
            n_checks++;
            n_errors++;
            $display("FAIL watchdog %s: actual=hung expected=finished", phase);
            $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
            $finish;
        end
    end

endmodule